// File: doc/BRIEF.md
# MMU Fault Status Capture

This block holds the status word that describes the most recent address-translation fault. When the table walker reports a fault, the block packs the fault type, the access index and a valid flag into the status word. If an earlier fault is still in the word because software has not read it yet, the block first marks overflow. It also decides whether the fault should reach the processor as a trap. A trap is withheld when the translation unit's no-fault control is set, or when the processor currently has traps disabled.

Software reads the word through a read strobe. The read returns the current contents combinationally and clears the word at the next clock edge. A walk that completes without a fault raises no strobe, so the word keeps its value. The fault address and the trap entry sequence are handled elsewhere.

Top module: `fsr_status_reg`

## Requirements
- R1: After reset the status word is zero and the trap request is low.
- R2: A fault strobe into a zero status word loads the following on the next edge: the access index at bits [7:5], the fault type at bits [4:2], and a 1 at bit 1 (valid). Bit 0 and all other bits are 0.
- R3: A fault strobe while the status word is nonzero, with no read in the same cycle, discards the old contents. The new word is 1 in bit 0 (overflow) ORed with the new fields placed as in R2.
- R4: A read strobe without a fault shows the current status word on the read data output in the same cycle. The word is zero after the next edge.
- R5: When a read strobe and a fault strobe fall in the same cycle, the fault is captured as if the word were empty. Bit 0 is 0 afterwards, and the read data shows the old word.
- R6: A fault while the no-fault control input is 1 still updates the status word but raises no trap request.
- R7: A fault while the processor trap-enable input is 0 still updates the status word but raises no trap request.
- R8: A fault with no-fault control 0 and trap-enable 1 raises the trap request for exactly the one cycle after the strobe edge. The trap request is low in any cycle that does not follow a fault strobe.
- R9: A cycle with neither a fault strobe nor a read strobe, such as a successful translation, leaves the status word unchanged.
- R10: Status word bits above the access index field always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_stb | input | 1 | Walker reports a fault this cycle |
| flt_type | input | TYPE_W (3) | Fault type code |
| flt_idx | input | IDX_W (3) | Access index (load/store, instruction/data, privilege) |
| nofault_en | input | 1 | Control bit that suppresses fault traps |
| trap_en | input | 1 | Processor trap-enable bit |
| rd_stb | input | 1 | Software read of the status word |
| rd_data | output | FSR_W (32) | Status word returned to the read |
| fsr_q | output | FSR_W (32) | Current status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench builds the block with its defaults: a 32-bit word and 3-bit type and index fields. With these values the whole field layout fits in bits [7:0], so every type and index code can be driven and 24 unused upper bits can be watched for stray writes. A sweep over all 64 type/index pairs is mixed with reads, same-cycle read-and-fault collisions and every combination of the two trap controls. This covers back-to-back overflow and the collision rule against a reference model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    // Bit positions decoded by software; fixed by behaviour.
    localparam int OVF_BIT  = 0;
    localparam int VLD_BIT  = 1;
    localparam int TYPE_LSB = 2;
endpackage

// File: rtl/fsr_field_pack.sv
module fsr_field_pack
    import fsr_pkg::*;
#(
    parameter int FSR_W  = 32,
    parameter int TYPE_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic [TYPE_W-1:0] flt_type,
    input  logic [IDX_W-1:0]  flt_idx,
    output logic [FSR_W-1:0]  fields
);
    localparam int IDX_LSB = TYPE_LSB + TYPE_W;

    always_comb begin
        fields                      = '0;
        fields[VLD_BIT]             = 1'b1;
        fields[TYPE_LSB +: TYPE_W]  = flt_type;
        fields[IDX_LSB +: IDX_W]    = flt_idx;
    end
endmodule

// File: rtl/fsr_merge.sv
module fsr_merge
    import fsr_pkg::*;
#(
    parameter int FSR_W = 32
) (
    input  logic [FSR_W-1:0] cur,
    input  logic [FSR_W-1:0] fields,
    input  logic             flt,
    input  logic             rd,
    output logic [FSR_W-1:0] nxt
);
    logic pending;

    always_comb begin
        // An unread word counts as pending unless this cycle reads it
        pending = (cur != '0) && !rd;
        nxt     = cur;
        if (flt) begin
            nxt          = '0;
            nxt[OVF_BIT] = pending;
            nxt          = nxt | fields;
        end else if (rd) begin
            nxt = '0;
        end
    end
endmodule

// File: rtl/fsr_trap_gate.sv
module fsr_trap_gate (
    input  logic flt,
    input  logic nofault_en,
    input  logic trap_en,
    output logic req
);
    always_comb begin
        req = flt && !nofault_en && trap_en;
    end
endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
    import fsr_pkg::*;
#(
    parameter int FSR_W  = 32,
    parameter int TYPE_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_stb,
    input  logic [TYPE_W-1:0] flt_type,
    input  logic [IDX_W-1:0]  flt_idx,
    input  logic              nofault_en,
    input  logic              trap_en,
    input  logic              rd_stb,
    output logic [FSR_W-1:0]  rd_data,
    output logic [FSR_W-1:0]  fsr_q,
    output logic              trap_req
);
    typedef struct packed {
        logic [FSR_W-1:0] fsr;
        logic             trap;
    } state_t;

    state_t           st_d, st_q;
    logic [FSR_W-1:0] fields;
    logic [FSR_W-1:0] merged;
    logic             trap_fire;

    fsr_field_pack #(
        .FSR_W  (FSR_W),
        .TYPE_W (TYPE_W),
        .IDX_W  (IDX_W)
    ) i_pack (
        .flt_type (flt_type),
        .flt_idx  (flt_idx),
        .fields   (fields)
    );

    fsr_merge #(
        .FSR_W (FSR_W)
    ) i_merge (
        .cur    (st_q.fsr),
        .fields (fields),
        .flt    (flt_stb),
        .rd     (rd_stb),
        .nxt    (merged)
    );

    fsr_trap_gate i_gate (
        .flt        (flt_stb),
        .nofault_en (nofault_en),
        .trap_en    (trap_en),
        .req        (trap_fire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fsr  = merged;
        st_d.trap = trap_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsr_q    = st_q.fsr;
    assign rd_data  = st_q.fsr;
    assign trap_req = st_q.trap;
endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk
    import fsr_pkg::*;
#(
    parameter int FSR_W  = 32,
    parameter int TYPE_W = 3,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_stb,
    input logic [TYPE_W-1:0] flt_type,
    input logic [IDX_W-1:0]  flt_idx,
    input logic              nofault_en,
    input logic              trap_en,
    input logic              rd_stb,
    input logic [FSR_W-1:0]  fsr_q,
    input logic              trap_req
);
    localparam int IDX_LSB = TYPE_LSB + TYPE_W;
    localparam int HI_LSB  = IDX_LSB + IDX_W;

    // R2
    fault_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> fsr_q[VLD_BIT]
                    && fsr_q[TYPE_LSB +: TYPE_W] == $past(flt_type)
                    && fsr_q[IDX_LSB +: IDX_W] == $past(flt_idx));

    // R3
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !rd_stb && fsr_q != '0) |=> fsr_q[OVF_BIT]);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && fsr_q == '0) |=> !fsr_q[OVF_BIT]);

    // R5
    read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && rd_stb) |=> !fsr_q[OVF_BIT]);

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !flt_stb) |=> fsr_q == '0);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !flt_stb) |=> $stable(fsr_q));

    // R6
    nofault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && nofault_en) |=> !trap_req);

    // R7
    trap_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !trap_en) |=> !trap_req);

    // R8
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !nofault_en && trap_en) |=> trap_req);

    // R8
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_stb |=> !trap_req);

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr_q >> HI_LSB) == '0);
endmodule

bind fsr_status_reg fsr_status_chk #(
    .FSR_W  (FSR_W),
    .TYPE_W (TYPE_W),
    .IDX_W  (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_stb    (flt_stb),
    .flt_type   (flt_type),
    .flt_idx    (flt_idx),
    .nofault_en (nofault_en),
    .trap_en    (trap_en),
    .rd_stb     (rd_stb),
    .fsr_q      (fsr_q),
    .trap_req   (trap_req)
);

// File: tb/test_fsr_status_reg.sv
module test_fsr_status_reg;
    localparam int FSR_W  = 32;
    localparam int TYPE_W = 3;
    localparam int IDX_W  = 3;

    typedef struct {
        logic [FSR_W-1:0] fsr;
        logic             trap;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flt_stb = 1'b0;
    logic [TYPE_W-1:0] flt_type = '0;
    logic [IDX_W-1:0]  flt_idx = '0;
    logic              nofault_en = 1'b0;
    logic              trap_en = 1'b0;
    logic              rd_stb = 1'b0;
    logic [FSR_W-1:0]  rd_data;
    logic [FSR_W-1:0]  fsr_q;
    logic              trap_req;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];
    logic [FSR_W-1:0] m_fsr = '0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    fsr_status_reg #(
        .FSR_W  (FSR_W),
        .TYPE_W (TYPE_W),
        .IDX_W  (IDX_W)
    ) i_fsr_status_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_stb    (flt_stb),
        .flt_type   (flt_type),
        .flt_idx    (flt_idx),
        .nofault_en (nofault_en),
        .trap_en    (trap_en),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .fsr_q      (fsr_q),
        .trap_req   (trap_req)
    );

    task automatic check_val(string tag, string what, logic [FSR_W-1:0] act,
                             logic [FSR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one transaction per cycle; pushes the post-edge expectation
    task automatic step(bit fv, int ty, int ix, bit nf, bit te, bit rd, string tag);
        exp_t e;
        logic [FSR_W-1:0] f;
        @(negedge clk);
        flt_stb    = fv;
        flt_type   = TYPE_W'(ty);
        flt_idx    = IDX_W'(ix);
        nofault_en = nf;
        trap_en    = te;
        rd_stb     = rd;
        #0.5;
        if (rd) check_val(tag, "rd_data", rd_data, m_fsr);
        // Layout: idx [7:5], type [4:2], valid bit 1, overflow bit 0
        f = FSR_W'((ix << 5) | (ty << 2) | 2);
        if (fv) begin
            if (m_fsr != '0 && !rd) m_fsr = FSR_W'(1) | f;
            else                    m_fsr = f;
        end else if (rd) begin
            m_fsr = '0;
        end
        e.fsr  = m_fsr;
        e.trap = fv && !nf && te;
        e.tag  = tag;
        sb_q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compares design outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_val(e.tag, "fsr_q", fsr_q, e.fsr);
                check_val(e.tag, "trap_req", FSR_W'(trap_req), FSR_W'(e.trap));
                // R10: upper bits
                check_val("R10", "upper bits", fsr_q >> 8, '0);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #7;
        // R1: reset state
        check_val("R1", "fsr_q", fsr_q, '0);
        check_val("R1", "trap_req", FSR_W'(trap_req), '0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 0, 0, 1, 0, "R9");
        step(1, 3, 2, 0, 1, 0, "R2");   // expect 0x4E, trap
        step(0, 0, 0, 0, 1, 0, "R9");   // hold 0x4E, trap low (R8)
        step(1, 5, 7, 0, 1, 0, "R3");   // expect 0xF7
        step(1, 1, 0, 0, 1, 0, "R3");   // expect 0x07
        step(0, 0, 0, 0, 1, 1, "R4");   // rd 0x07, then 0
        step(0, 0, 0, 0, 1, 0, "R9");
        step(1, 2, 1, 1, 1, 0, "R6");   // 0x2A, no trap
        step(1, 6, 4, 0, 0, 1, "R5");   // rd 0x2A, then 0x9A, no trap (R7)
        step(1, 7, 3, 0, 0, 0, "R7");   // 0x7F, no trap
        step(1, 4, 5, 0, 1, 0, "R8");   // trap
        step(0, 0, 0, 0, 1, 0, "R8");   // trap drops
        step(0, 0, 0, 0, 1, 1, "R4");

        for (int t = 0; t < 8; t++) begin
            for (int x = 0; x < 8; x++) begin
                step(1, t, x, (t + x) % 3 == 0, x % 2 == 0, (t * 8 + x) % 5 == 0,
                     ((t * 8 + x) % 5 == 0) ? "R5" : "R3");
                if (x % 3 == 2) step(0, 0, 0, 0, 1, 1, "R4");
            end
        end
        step(0, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, 1, 0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule